// File: doc/BRIEF.md
# Stuck-At Fault Injection Wrapper

This block wraps a small three-input combinational circuit, whose output is the inverse of (a AND b), ORed with c, so that a single stuck-at fault can be forced onto any one of its five nets. The five nets are the three data inputs, the internal net between the NAND and the OR, and the final output. At each net the normal signal is cut and replaced by a two-level selection. The first level chooses between the normal value and a forced value. The second level chooses whether the forced value is a constant 0 or a constant 1.

A second copy of the logic never receives a fault and drives a reference output. Both outputs are valid together, so test logic can XOR them to tell whether the applied data vector exposes the injected fault. A 1 from that XOR means the vector detects the fault. The block holds no state, and its outputs follow its inputs with no clock involved.

Top module: `fij_stuck_at_wrap`

## Requirements
- R1: While `fault_on` is 0, `out_dut` equals `out_ref` for every data vector and every value of `stuck_high` and `node_sel`.
- R2: `out_ref` always equals (NOT(`a_in` AND `b_in`)) OR `c_in`, whatever the fault controls are.
- R3: While `fault_on` is 1 and `node_sel` is 0 (`a_in`), 1 (`b_in`), 2 (`c_in`) or 3 (the internal NAND net), `out_dut` equals the circuit function with the selected net replaced by `stuck_high`. A `stuck_high` of 0 means stuck-at-0 and a `stuck_high` of 1 means stuck-at-1.
- R4: While `fault_on` is 1 and `node_sel` is 4 (the output net), `out_dut` equals `stuck_high` for every data vector.
- R5: Values 5, 6 and 7 of `node_sel` inject no fault, so `out_dut` equals `out_ref`.
- R6: Detection, meaning `out_dut` XOR `out_ref` = 1, follows the circuit's logic. Vector a,b,c = 1,1,0 detects a stuck-at-0, b stuck-at-0, c stuck-at-1 and internal stuck-at-1. Vector 1,0,0 detects b stuck-at-1 and internal stuck-at-0. Vector 0,1,0 detects a stuck-at-1. Vector 1,1,1 detects c stuck-at-0.
- R7: Both outputs respond to an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | 1 | Data input a, first NAND operand |
| b_in | input | 1 | Data input b, second NAND operand |
| c_in | input | 1 | Data input c, OR operand |
| fault_on | input | 1 | 1 applies the selected fault, 0 gives normal operation |
| stuck_high | input | 1 | Forced value: 0 for stuck-at-0, 1 for stuck-at-1 |
| node_sel | input | 3 | Net to fault: 0 a, 1 b, 2 c, 3 internal, 4 output, 5 to 7 none |
| out_dut | output | 1 | Output of the circuit with the fault applied |
| out_ref | output | 1 | Output of the fault-free copy |

## Verification
The bench sweeps all 256 combinations of the data bits, the enable, the fault type and the selector. This sweep tells the five nets apart from one another and separates the unused selector codes from the used ones. It also confirms that a disabled fault never leaks to the output. A directed pass then applies the four minimal test vectors to each of the ten faults and checks which faults each vector detects and which it misses. That separates a fault on the internal net from a fault on its NAND operands. Seeded random stimulus then changes inputs between clock edges to show that the outputs settle without a clock.

// File: rtl/fij_pkg.sv
package fij_pkg;

    localparam int NODE_CNT = 5;
    localparam int SEL_W    = $clog2(NODE_CNT + 1);
    localparam int DATA_IN  = 3;

    typedef enum logic [SEL_W-1:0] {
        NODE_A   = 3'd0,
        NODE_B   = 3'd1,
        NODE_C   = 3'd2,
        NODE_MID = 3'd3,
        NODE_OUT = 3'd4
    } node_e;

    typedef struct packed {
        logic force_en;
        logic force_val;
    } fault_ctl_t;

    localparam fault_ctl_t CTL_IDLE = '{force_en: 1'b0, force_val: 1'b0};

    function automatic logic nand_or_eval(input logic a, input logic b, input logic c);
        return (~(a & b)) | c;
    endfunction

    function automatic logic level_of(input logic stuck_one);
        return stuck_one ? 1'b1 : 1'b0;
    endfunction

endpackage

// File: rtl/fij_select_decode.sv
module fij_select_decode
    import fij_pkg::*;
(
    input  logic                            fault_on,
    input  logic                            stuck_high,
    input  logic [SEL_W-1:0]                node_sel,
    output fault_ctl_t [NODE_CNT-1:0]       ctl
);
    for (genvar i = 0; i < NODE_CNT; i++) begin : g_node
        always_comb begin
            ctl[i] = CTL_IDLE;
            if (fault_on && (node_sel == SEL_W'(i))) begin
                ctl[i].force_en  = 1'b1;
                ctl[i].force_val = stuck_high;
            end
        end
    end
endmodule

// File: rtl/fij_force_point.sv
module fij_force_point
    import fij_pkg::*;
(
    input  logic       d,
    input  fault_ctl_t ctl,
    output logic       q
);
    logic forced_level;

    always_comb begin
        forced_level = level_of(ctl.force_val);
        q            = ctl.force_en ? forced_level : d;
    end
endmodule

// File: rtl/fij_nand_or_core.sv
module fij_nand_or_core
    import fij_pkg::*;
(
    input  logic [DATA_IN-1:0]        din,
    input  fault_ctl_t [NODE_CNT-1:0] ctl,
    output logic                      y
);
    logic [DATA_IN-1:0] din_f;
    logic               mid_raw;
    logic               mid_f;
    logic               out_raw;

    for (genvar i = 0; i < DATA_IN; i++) begin : g_in
        fij_force_point i_fp (
            .d   (din[i]),
            .ctl (ctl[i]),
            .q   (din_f[i])
        );
    end

    always_comb mid_raw = ~(din_f[NODE_A] & din_f[NODE_B]);

    fij_force_point i_fp_mid (
        .d   (mid_raw),
        .ctl (ctl[NODE_MID]),
        .q   (mid_f)
    );

    always_comb out_raw = mid_f | din_f[NODE_C];

    fij_force_point i_fp_out (
        .d   (out_raw),
        .ctl (ctl[NODE_OUT]),
        .q   (y)
    );
endmodule

// File: rtl/fij_stuck_at_wrap.sv
module fij_stuck_at_wrap
    import fij_pkg::*;
(
    input  logic             a_in,
    input  logic             b_in,
    input  logic             c_in,
    input  logic             fault_on,
    input  logic             stuck_high,
    input  logic [SEL_W-1:0] node_sel,
    output logic             out_dut,
    output logic             out_ref
);
    fault_ctl_t [NODE_CNT-1:0] ctl;
    logic [DATA_IN-1:0]        din;

    always_comb begin
        din         = '0;
        din[NODE_A] = a_in;
        din[NODE_B] = b_in;
        din[NODE_C] = c_in;
    end

    fij_select_decode i_dec (
        .fault_on   (fault_on),
        .stuck_high (stuck_high),
        .node_sel   (node_sel),
        .ctl        (ctl)
    );

    fij_nand_or_core i_core (
        .din (din),
        .ctl (ctl),
        .y   (out_dut)
    );

    always_comb out_ref = nand_or_eval(a_in, b_in, c_in);
endmodule

// File: rtl/fij_stuck_at_chk.sv
module fij_stuck_at_chk
    import fij_pkg::*;
(
    input logic             a_in,
    input logic             b_in,
    input logic             c_in,
    input logic             fault_on,
    input logic             stuck_high,
    input logic [SEL_W-1:0] node_sel,
    input logic             out_dut,
    input logic             out_ref
);
    always_comb begin
        if (!fault_on)
            assert_no_fault_match_R1: assert (out_dut == out_ref);
        if (c_in)
            assert_ref_c_high_R2: assert (out_ref == 1'b1);
        if (a_in && b_in && !c_in)
            assert_ref_low_R2: assert (out_ref == 1'b0);
        if (fault_on && node_sel == 3'd2 && stuck_high)
            assert_c_stuck_one_R3: assert (out_dut == 1'b1);
        if (fault_on && node_sel == 3'd3 && !stuck_high)
            assert_mid_stuck_zero_R3: assert (out_dut == c_in);
        if (fault_on && node_sel == 3'd4)
            assert_out_forced_R4: assert (out_dut == stuck_high);
        if (node_sel > 3'd4)
            assert_unused_code_R5: assert (out_dut == out_ref);
    end
endmodule

bind fij_stuck_at_wrap fij_stuck_at_chk i_chk (.*);

// File: tb/test_fij_stuck_at_wrap.sv
module test_fij_stuck_at_wrap;
    logic       clk = 1'b0;
    logic       rst;
    logic       a_in, b_in, c_in, fault_on, stuck_high;
    logic [2:0] node_sel;
    logic       out_dut, out_ref;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #5 clk = ~clk;

    fij_stuck_at_wrap i_fij_stuck_at_wrap (
        .a_in(a_in), .b_in(b_in), .c_in(c_in), .fault_on(fault_on),
        .stuck_high(stuck_high), .node_sel(node_sel),
        .out_dut(out_dut), .out_ref(out_ref)
    );

    function automatic logic ref_fn(input logic a, input logic b, input logic c);
        return !(a && b) || c;
    endfunction

    function automatic logic dut_fn(input logic a, input logic b, input logic c,
                                    input logic en, input logic v, input logic [2:0] s);
        logic aa, bb, cc, m, o;
        aa = (en && s == 3'd0) ? v : a;
        bb = (en && s == 3'd1) ? v : b;
        cc = (en && s == 3'd2) ? v : c;
        m  = !(aa && bb);
        if (en && s == 3'd3) m = v;
        o  = m || cc;
        if (en && s == 3'd4) o = v;
        return o;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b (abc=%b%b%b en=%b v=%b sel=%0d)",
                     req, act, exp, a_in, b_in, c_in, fault_on, stuck_high, node_sel);
        end
    endtask

    task automatic apply(input logic [2:0] abc, input logic en, input logic v, input logic [2:0] s);
        {a_in, b_in, c_in} = abc;
        fault_on   = en;
        stuck_high = v;
        node_sel   = s;
    endtask

    task automatic check_all(input string prefix);
        logic e;
        e = dut_fn(a_in, b_in, c_in, fault_on, stuck_high, node_sel);
        check("R2", out_ref, ref_fn(a_in, b_in, c_in));
        if (!fault_on)           check({prefix, " R1"}, out_dut, e);
        else if (node_sel > 4)   check({prefix, " R5"}, out_dut, e);
        else if (node_sel == 4)  check({prefix, " R4"}, out_dut, e);
        else                     check({prefix, " R3"}, out_dut, e);
    endtask

    // detection table: expected detect bit for vector idx, fault (sel, val)
    function automatic logic det_exp(input logic [2:0] abc, input logic [2:0] s, input logic v);
        return dut_fn(abc[2], abc[1], abc[0], 1'b1, v, s) ^ ref_fn(abc[2], abc[1], abc[0]);
    endfunction

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1;
        apply(3'b000, 1'b0, 1'b0, 3'd0);
        @(negedge clk);
        #1 check("R1 reset", out_dut, 1'b1);
        check("R2 reset", out_ref, 1'b1);
        @(negedge clk);
        rst = 1'b0;

        // exhaustive sweep
        for (int k = 0; k < 256; k++) begin
            @(negedge clk);
            apply(k[2:0], k[3], k[4], k[7:5]);
            #1 check_all("sweep");
        end

        // R6 detection with the four minimal vectors
        begin
            logic [2:0] vecs [4];
            vecs[0] = 3'b110; vecs[1] = 3'b100; vecs[2] = 3'b010; vecs[3] = 3'b111;
            for (int vi = 0; vi < 4; vi++) begin
                for (int f = 0; f < 10; f++) begin
                    @(negedge clk);
                    apply(vecs[vi], 1'b1, f[0], 3'(f >> 1));
                    #1 check("R6 detect", out_dut ^ out_ref, det_exp(vecs[vi], 3'(f >> 1), f[0]));
                end
            end
        end
        // R6 directed spot checks
        @(negedge clk); apply(3'b110, 1'b1, 1'b1, 3'd3);
        #1 check("R6 110 mid@1", out_dut ^ out_ref, 1'b1);
        @(negedge clk); apply(3'b100, 1'b1, 1'b0, 3'd3);
        #1 check("R6 100 mid@0", out_dut ^ out_ref, 1'b1);
        @(negedge clk); apply(3'b010, 1'b1, 1'b1, 3'd0);
        #1 check("R6 010 a@1", out_dut ^ out_ref, 1'b1);
        @(negedge clk); apply(3'b111, 1'b1, 1'b0, 3'd2);
        #1 check("R6 111 c@0", out_dut ^ out_ref, 1'b1);
        @(negedge clk); apply(3'b111, 1'b1, 1'b0, 3'd0);
        #1 check("R6 111 misses a@0", out_dut ^ out_ref, 1'b0);

        // random, several changes inside one clock period (R7)
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            for (int j = 0; j < 3; j++) begin
                apply(3'($urandom), 1'($urandom), 1'($urandom), 3'($urandom));
                #1 check_all("R7 random");
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule